// File: doc/BRIEF.md
# UART Operation-Mode Register with Enable Gating

This block is the 8-bit operation-mode register of an asynchronous serial transceiver. Software writes it either as a whole byte or one bit at a time. It reads back unchanged. From the stored bits it produces the control signals that the rest of the transceiver needs. The framing fields (parity choice, character length, stop length and receive-error interrupt mode) are passed straight out to the shift and parity logic.

The top bit is a master power bit. While it is clear, the operation-clock enable is held low and the downstream reset is held active. When the bit is set again, that reset is released one cycle later, in step with the clock.

Below the master bit, each direction has its own enable bit. Clearing one of them while power stays on gives a one-cycle synchronous reset pulse to that direction's engine only. While power is off, the transmit line is held at the idle (high) level, and the receive line seen by the receiver is also held high.

Top module: `uart_mode_ctl`

## Requirements
- R1: After reset, rd_data reads 0x01.
- R2: With wr_en=1 and wr_bit=0, wr_data is stored at the next clock edge. rd_data always shows the stored byte, and reading it has no side effect.
- R3: With wr_en=1 and wr_bit=1, only bit wr_sel is written, and it takes the value wr_data[0]. The other seven bits keep their values.
- R4: The framing outputs are taken from the stored byte: par_sel is bits 4:3, char_len is bit 2, stop_len is bit 1 and err_mode is bit 0.
- R5: Whenever bit 7 (power) reads 0, op_clk_en and core_rst_n are both 0 in that same cycle.
- R6: In the first cycle that bit 7 reads 1 after reading 0, core_rst_n and op_clk_en are still 0. From the second such cycle on, both are 1.
- R7: tx_run equals core_rst_n AND bit 6. rx_run equals core_rst_n AND bit 5.
- R8: If bit 6 changes from 1 to 0 at an edge where bit 7 stays 1, tx_srst is 1 for exactly the first cycle in which bit 6 reads 0. Bit 5 drives rx_srst the same way. No other change raises either pulse.
- R9: Writing back the value already stored leaves core_rst_n, tx_run and rx_run unchanged and raises neither tx_srst nor rx_srst.
- R10: txd_pin is 1 while bit 7 reads 0. Otherwise txd_pin equals txd_eng.
- R11: rxd_eng is 1 while bit 7 reads 0. Otherwise rxd_eng equals rxd_pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_bit | input | 1 | 1 selects a single-bit write, 0 a byte write |
| wr_sel | input | 3 | Bit index for a single-bit write |
| wr_data | input | 8 | Byte data; bit 0 is the value in a single-bit write |
| rd_data | output | 8 | Stored register value |
| op_clk_en | output | 1 | Enable for the engines' operation clock |
| core_rst_n | output | 1 | Active-low reset for downstream status and buffers |
| tx_run | output | 1 | Transmit engine enabled |
| rx_run | output | 1 | Receive engine enabled |
| tx_srst | output | 1 | One-cycle synchronous reset of the transmit engine |
| rx_srst | output | 1 | One-cycle synchronous reset of the receive engine |
| par_sel | output | 2 | Parity selection field |
| char_len | output | 1 | Character length selection |
| stop_len | output | 1 | Stop length selection |
| err_mode | output | 1 | Receive-error interrupt mode |
| txd_eng | input | 1 | Serial data from the transmit engine |
| txd_pin | output | 1 | Serial output line |
| rxd_pin | input | 1 | Serial input line |
| rxd_eng | output | 1 | Serial data delivered to the receive engine |

## Verification
A stored bit that is wrong appears on rd_data and on the decoded outputs in the cycle right after the write edge. The bench compares every output on every clock, so such an error is caught within one cycle.

A release flag that is stuck or late shows as core_rst_n rising at the wrong cycle after power is set. A mis-detected enable edge shows as a missing, doubled or spurious pulse on tx_srst or rx_srst. Both are caught in the cycle where they happen.

Mixed byte and single-bit write sequences, including identical rewrites and the power bit toggling, drive each of these paths.

// File: rtl/uart_mode_pkg.sv
package uart_mode_pkg;
  localparam int MODE_W  = 8;
  localparam int SEL_W   = $clog2(MODE_W);
  localparam int PWR_B   = 7;
  localparam int TXE_B   = 6;
  localparam int RXE_B   = 5;
  localparam int PAR_HI  = 4;
  localparam int PAR_LO  = 3;
  localparam int CLEN_B  = 2;
  localparam int SLEN_B  = 1;
  localparam int EMOD_B  = 0;
  localparam int PAR_W   = PAR_HI - PAR_LO + 1;
  typedef logic [MODE_W-1:0] mode_t;
endpackage

// File: rtl/mode_reg_file.sv
module mode_reg_file
  import uart_mode_pkg::*;
#(
  parameter mode_t RST_VAL = mode_t'(8'h01)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_bit,
  input  logic [SEL_W-1:0] wr_sel,
  input  mode_t            wr_data,
  output mode_t            mode_q,
  output mode_t            mode_d
);
  mode_t bit_merge;

  // Next-state logic: a single-bit write merges wr_data[0] into the selected bit.
  always_comb begin
    bit_merge = mode_q;
    for (int i = 0; i < MODE_W; i++) begin
      if (wr_sel == SEL_W'(i)) bit_merge[i] = wr_data[0];
    end
    mode_d = mode_q;
    if (wr_en) mode_d = wr_bit ? bit_merge : wr_data;
  end

  // Register process with an explicit clock enable.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mode_q <= RST_VAL;
    else if (wr_en) mode_q <= mode_d;
  end

  // R3
  bit_write_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_bit) |=> ((mode_q ^ $past(mode_q)) & ~(mode_t'(1) << $past(wr_sel))) == '0);
endmodule

// File: rtl/mode_rst_gen.sv
module mode_rst_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_q,
  input  logic txe_q,
  input  logic rxe_q,
  input  logic pwr_d,
  input  logic txe_d,
  input  logic rxe_d,
  output logic op_clk_en,
  output logic core_rst_n,
  output logic tx_run,
  output logic rx_run,
  output logic tx_srst,
  output logic rx_srst
);
  logic rel_q, rel_d;
  logic txs_q, txs_d;
  logic rxs_q, rxs_d;

  // Next-state logic.
  always_comb begin
    rel_d = pwr_q;
    txs_d = pwr_q & pwr_d & txe_q & ~txe_d;
    rxs_d = pwr_q & pwr_d & rxe_q & ~rxe_d;
  end

  // Register process.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_q <= 1'b0;
      txs_q <= 1'b0;
      rxs_q <= 1'b0;
    end else begin
      rel_q <= rel_d;
      txs_q <= txs_d;
      rxs_q <= rxs_d;
    end
  end

  // Reset asserts as soon as power drops and is released one edge after power returns.
  assign core_rst_n = pwr_q & rel_q;
  assign op_clk_en  = core_rst_n;
  assign tx_run     = core_rst_n & txe_q;
  assign rx_run     = core_rst_n & rxe_q;
  assign tx_srst    = txs_q;
  assign rx_srst    = rxs_q;

  // R8
  tx_srst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_srst |=> !tx_srst);
  // R8
  rx_srst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_srst |=> !rx_srst);
endmodule

// File: rtl/mode_pin_safe.sv
module mode_pin_safe #(
  parameter int LANES = 2
) (
  input  logic             pwr_on,
  input  logic [LANES-1:0] raw_in,
  output logic [LANES-1:0] safe_out
);
  // Each lane is held at the idle-high level while power is off.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign safe_out[g] = pwr_on ? raw_in[g] : 1'b1;
  end
endmodule

// File: rtl/uart_mode_ctl.sv
module uart_mode_ctl
  import uart_mode_pkg::*;
#(
  parameter logic [7:0] RST_VAL = 8'h01
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_bit,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       op_clk_en,
  output logic       core_rst_n,
  output logic       tx_run,
  output logic       rx_run,
  output logic       tx_srst,
  output logic       rx_srst,
  output logic [1:0] par_sel,
  output logic       char_len,
  output logic       stop_len,
  output logic       err_mode,
  input  logic       txd_eng,
  output logic       txd_pin,
  input  logic       rxd_pin,
  output logic       rxd_eng
);
  mode_t mode_q, mode_d;
  logic [1:0] pin_raw, pin_safe;

  mode_reg_file #(.RST_VAL(mode_t'(RST_VAL))) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_bit  (wr_bit),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .mode_q  (mode_q),
    .mode_d  (mode_d)
  );

  mode_rst_gen u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_q      (mode_q[PWR_B]),
    .txe_q      (mode_q[TXE_B]),
    .rxe_q      (mode_q[RXE_B]),
    .pwr_d      (mode_d[PWR_B]),
    .txe_d      (mode_d[TXE_B]),
    .rxe_d      (mode_d[RXE_B]),
    .op_clk_en  (op_clk_en),
    .core_rst_n (core_rst_n),
    .tx_run     (tx_run),
    .rx_run     (rx_run),
    .tx_srst    (tx_srst),
    .rx_srst    (rx_srst)
  );

  assign pin_raw = {rxd_pin, txd_eng};

  mode_pin_safe #(.LANES(2)) u_pins (
    .pwr_on   (mode_q[PWR_B]),
    .raw_in   (pin_raw),
    .safe_out (pin_safe)
  );

  assign txd_pin  = pin_safe[0];
  assign rxd_eng  = pin_safe[1];
  assign rd_data  = mode_q;
  assign par_sel  = mode_q[PAR_HI:PAR_LO];
  assign char_len = mode_q[CLEN_B];
  assign stop_len = mode_q[SLEN_B];
  assign err_mode = mode_q[EMOD_B];

  // R5
  pwr_off_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[PWR_B] |-> (!core_rst_n && !op_clk_en));
  // R6
  pwr_rise_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[PWR_B]) |-> !core_rst_n);
  // R6
  pwr_steady_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[PWR_B] && $past(rd_data[PWR_B])) |-> core_rst_n);
  // R8
  tx_srst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_srst |-> ($past(rd_data[TXE_B]) && !rd_data[TXE_B] && rd_data[PWR_B]));
  // R9
  same_value_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data == $past(rd_data)) |-> (!tx_srst && !rx_srst));
  // R10
  txd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[PWR_B] |-> txd_pin);
endmodule

// File: tb/uart_mode_ctl_test.sv
module uart_mode_ctl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_bit = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic txd_eng = 1'b0, rxd_pin = 1'b0;
  logic [7:0] rd_data;
  logic op_clk_en, core_rst_n, tx_run, rx_run, tx_srst, rx_srst;
  logic [1:0] par_sel;
  logic char_len, stop_len, err_mode, txd_pin, rxd_eng;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Behavioural reference state.
  logic [7:0] m_reg;
  logic m_on_prev;
  logic m_txp, m_rxp;

  always #2 clk = ~clk;

  uart_mode_ctl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bit(wr_bit), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_data(rd_data), .op_clk_en(op_clk_en),
    .core_rst_n(core_rst_n), .tx_run(tx_run), .rx_run(rx_run),
    .tx_srst(tx_srst), .rx_srst(rx_srst), .par_sel(par_sel),
    .char_len(char_len), .stop_len(stop_len), .err_mode(err_mode),
    .txd_eng(txd_eng), .txd_pin(txd_pin), .rxd_pin(rxd_pin), .rxd_eng(rxd_eng)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg <= 8'h01; m_on_prev <= 1'b0; m_txp <= 1'b0; m_rxp <= 1'b0;
    end else begin
      logic [7:0] nv;
      nv = m_reg;
      if (wr_en) begin
        if (wr_bit) nv[wr_sel] = wr_data[0];
        else nv = wr_data;
      end
      m_on_prev <= m_reg[7];
      m_txp <= (m_reg[7] == 1'b1) && (nv[7] == 1'b1) && (m_reg[6] == 1'b1) && (nv[6] == 1'b0);
      m_rxp <= (m_reg[7] == 1'b1) && (nv[7] == 1'b1) && (m_reg[5] == 1'b1) && (nv[5] == 1'b0);
      m_reg <= nv;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic on;
      on = m_reg[7] && m_on_prev;
      chk("R1/R2 rd_data", rd_data, m_reg);
      chk("R4 par_sel", par_sel, m_reg[4:3]);
      chk("R4 char/stop/err", {char_len, stop_len, err_mode}, m_reg[2:0]);
      chk("R5/R6 core_rst_n", core_rst_n, on);
      chk("R5/R6 op_clk_en", op_clk_en, on);
      chk("R7 tx_run", tx_run, on && m_reg[6]);
      chk("R7 rx_run", rx_run, on && m_reg[5]);
      chk("R8 tx_srst", tx_srst, m_txp);
      chk("R8 rx_srst", rx_srst, m_rxp);
      chk("R10 txd_pin", txd_pin, m_reg[7] ? txd_eng : 1'b1);
      chk("R11 rxd_eng", rxd_eng, m_reg[7] ? rxd_pin : 1'b1);
    end
  end

  task automatic cyc(input logic en, input logic bm, input logic [2:0] s, input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = en; wr_bit = bm; wr_sel = s; wr_data = d;
    txd_eng = $urandom_range(0, 1); rxd_pin = $urandom_range(0, 1);
  endtask

  task automatic byte_wr(input logic [7:0] d);
    cyc(1'b1, 1'b0, 3'd0, d);
    cyc(1'b0, 1'b0, 3'd0, 8'h00);
  endtask

  task automatic bit_wr(input logic [2:0] s, input logic v);
    cyc(1'b1, 1'b1, s, {7'h55, v});
    cyc(1'b0, 1'b0, 3'd0, 8'h00);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) cyc(1'b0, 1'b0, 3'd0, 8'h00);    // R1 reset value observed
    byte_wr(8'hE0);                                // R2 power, tx, rx on
    repeat (4) cyc(1'b0, 1'b0, 3'd0, 8'h00);    // R6 release, R10/R11 passthrough
    bit_wr(3'd6, 1'b0);                            // R8 tx pulse
    bit_wr(3'd5, 1'b0);                            // R8 rx pulse
    bit_wr(3'd6, 1'b1);                            // R3 set only bit 6
    byte_wr(8'hC0);                                // R9 rewrite same value
    byte_wr(8'hC0);
    byte_wr(8'hDE);                                // R4 framing fields
    bit_wr(3'd7, 1'b0);                            // R5 power off with tx on: no pulse
    bit_wr(3'd7, 1'b1);                            // R6 power back
    byte_wr(8'h9A);                                // R8 tx off with power kept
    for (int i = 0; i < 400; i++) begin
      cyc($urandom_range(0, 2) == 0, $urandom_range(0, 1), 3'($urandom_range(0, 7)),
          ($urandom_range(0, 5) == 0) ? rd_data : 8'($urandom_range(0, 255)));
    end
    cyc(1'b0, 1'b0, 3'd0, 8'h00);
    @(negedge clk); #1;
    finish_run();
  end
endmodule